// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block decides, for a two-port PCI-to-PCI bridge, when the bridge drives the active-low data parity error signal on its primary bus and on its secondary bus. It checks even parity on each bus's address/data and command/byte-enable lines against the parity bit. That bit arrives one clock after the data it covers. The block then decides, from the transaction kind, the direction and the bus where the error was seen, whether the error is reported and on which side.

The bridge only reports an error on a bus where it is the target of a write or the initiator of a read, and only while that bus's parity-error-response enable is set. For a delayed write, an error signalled by the far-side device during the completion is forwarded across the bridge. The forwarded error is reported only when both enables are set. Each output comes with a drive enable. The reporter drives the line low for one clock per errored data phase, drives it high for one clock, and then releases it, as the bus protocol requires. The pad drivers are outside the block.

The transaction attributes and the forwarded-error indicator are shared by both buses. They are latched in any cycle where either bus presents a data phase.

Top module: `bridge_perr_reporter`

## Requirements
- R1: Each bus computes even parity over its 32 address/data bits and 4 command/byte-enable bits in a cycle whose phase-valid input is high. It compares the result with that bus's parity input in the following cycle. A mismatch is a parity error on that bus, and no error is raised when the two agree.
- R2: A reported error drives the chosen PERR# output low (with its drive enable high) in the second clock after the data phase. The output is still high and undriven in the first clock after the phase.
- R3: After its last low cycle an asserted output is driven high for exactly one clock and is then released (drive enable low, level high). A new report that lands in the driven-high cycle pulls the line low again.
- R4: Errored data phases in consecutive cycles keep the output low for one clock per phase, with no high cycle between them.
- R5: A primary-bus parity error is reported on the primary output for an upstream read, a downstream posted write or a downstream delayed write. The only gate is the primary enable.
- R6: A secondary-bus parity error is reported on the secondary output for a downstream read, an upstream posted write or an upstream delayed write. The only gate is the secondary enable.
- R7: No output is asserted for a parity error in any other combination of bus, kind and direction. These are a downstream read on the primary bus, an upstream read on the secondary bus, a posted write on the bus where the bridge is initiator, and a delayed write error on the target bus.
- R8: A cleared parity-error-response enable suppresses local reports on its own side, and has no effect on local reports on the other side.
- R9: A far-side error indicated during a delayed-write completion is forwarded. For a downstream delayed write it is reported on the primary output, and for an upstream delayed write on the secondary output, in both cases only when both enables are set. For a read or a posted write the indicator is ignored.
- R10: The kind code is 2'b00 read, 2'b01 posted write, 2'b10 delayed write and 2'b11 reserved, which never reports. The direction bit is 0 for downstream and 1 for upstream. The attributes and the far-side indicator are latched only in a cycle where a bus phase is valid.
- R11: A synchronous active-low reset releases both outputs (high, drive enable low) and discards any error still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_ad | input | 32 | Primary address/data lines |
| pri_cbe_n | input | 4 | Primary command/byte-enable lines (pin levels) |
| pri_par | input | 1 | Primary parity bit, one clock after its data |
| pri_phase_vld | input | 1 | Primary data phase to be checked this cycle |
| sec_ad | input | 32 | Secondary address/data lines |
| sec_cbe_n | input | 4 | Secondary command/byte-enable lines (pin levels) |
| sec_par | input | 1 | Secondary parity bit, one clock after its data |
| sec_phase_vld | input | 1 | Secondary data phase to be checked this cycle |
| xact_kind | input | 2 | Transaction kind code (see R10) |
| xact_up | input | 1 | Direction: 0 downstream, 1 upstream |
| far_perr_seen | input | 1 | Far-side PERR# sampled during a delayed-write completion |
| pri_resp_en | input | 1 | Primary parity-error-response enable |
| sec_resp_en | input | 1 | Secondary parity-error-response enable |
| pri_perr_n | output | 1 | Primary PERR# level |
| pri_perr_oe | output | 1 | Primary PERR# drive enable |
| sec_perr_n | output | 1 | Secondary PERR# level |
| sec_perr_oe | output | 1 | Secondary PERR# drive enable |

## Verification
Two of the block's functions can fall in the same cycle, and the bench provokes both cases.

The first case puts a local parity error on the primary bus and a forwarded far-side error on the same downstream delayed-write phase. The bench judges it correct when only the primary output is asserted, for a single low cycle followed by the usual high cycle and release.

The second case sends a new report in the exact cycle where an earlier report is being driven high before release. The bench issues two errored phases one idle cycle apart. It expects the sequence low, high, low, high, released, sampled clock by clock.

// File: rtl/perr_pkg.sv
`timescale 1ns/1ps
// Shared types for the bridge parity error reporter.
// Assumes the kind code values are fixed by the block's interface.
package perr_pkg;

    // Transaction kind code carried on xact_kind
    typedef enum logic [1:0] {
        XK_READ    = 2'b00,
        XK_POSTED  = 2'b01,
        XK_DELAYED = 2'b10,
        XK_RSVD    = 2'b11
    } xact_kind_e;

    // State of one PERR# output driver
    typedef enum logic [1:0] {
        DRV_IDLE = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_HIGH = 2'b10
    } drv_state_e;

    // Transaction attributes captured with a data phase
    typedef struct packed {
        logic       any_vld;
        xact_kind_e kind;
        logic       up;
        logic       fwd;
    } phase_attr_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_PRI  = 0;
    localparam int unsigned SIDE_SEC  = 1;

endpackage

// File: rtl/perr_parity_chk.sv
`timescale 1ns/1ps
// Even parity checker for one bus.
// In a valid data phase it folds the address/data and command/byte-enable
// lines into one expected parity bit and registers it. In the next cycle
// it compares that bit with the bus parity input and flags a mismatch.
// Assumes the parity input always arrives exactly one clock after its data.
module perr_parity_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    input  logic              phase_vld,
    input  logic              par,
    output logic              par_err
);
    localparam int unsigned COVER_W = DATA_W + CMD_W;

    logic [COVER_W-1:0] covered;
    logic               exp_par_q;
    logic               vld_q;

    assign covered = {ad, cbe_n};

    // Capture the folded parity of the current phase for next-cycle compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_par_q <= 1'b0;
            vld_q     <= 1'b0;
        end else begin
            exp_par_q <= ^covered;
            vld_q     <= phase_vld;
        end
    end

    // Flag a mismatch between delivered and expected parity
    assign par_err = vld_q && (par != exp_par_q);

    // R1
    err_needs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(phase_vld));

endmodule

// File: rtl/perr_policy.sv
`timescale 1ns/1ps
// Reporting policy. It maps the parity errors of both buses, the latched
// transaction attributes and both response enables to one report request
// per side. It is purely combinational; clk/rst_n serve only its checks.
// Assumes the attributes belong to the phase whose parity is compared now.
module perr_policy
    import perr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pri_err,
    input  logic        sec_err,
    input  phase_attr_t attr,
    input  logic        pri_en,
    input  logic        sec_en,
    output logic        pri_rep,
    output logic        sec_rep
);
    logic is_rd;
    logic is_pw;
    logic is_dw;
    logic pri_local;
    logic sec_local;
    logic pri_fwd;
    logic sec_fwd;

    // Decode the kind code
    always_comb begin
        is_rd = (attr.kind == XK_READ);
        is_pw = (attr.kind == XK_POSTED);
        is_dw = (attr.kind == XK_DELAYED);
    end

    // Local errors: the bridge is target of a write or initiator of a read there
    always_comb begin
        pri_local = pri_err && pri_en &&
                    ((is_rd && attr.up) || ((is_pw || is_dw) && !attr.up));
        sec_local = sec_err && sec_en &&
                    ((is_rd && !attr.up) || ((is_pw || is_dw) && attr.up));
    end

    // Forwarded far-side errors of a delayed-write completion
    always_comb begin
        pri_fwd = attr.any_vld && attr.fwd && is_dw && !attr.up && pri_en && sec_en;
        sec_fwd = attr.any_vld && attr.fwd && is_dw &&  attr.up && pri_en && sec_en;
    end

    // Merge local and forwarded reasons per side
    assign pri_rep = pri_local || pri_fwd;
    assign sec_rep = sec_local || sec_fwd;

    // R8
    pri_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_rep |-> pri_en);
    // R8
    sec_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rep |-> sec_en);
    // R10
    rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr.kind == XK_RSVD) |-> !(pri_rep || sec_rep));
    // R7
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_rep && sec_rep));

endmodule

// File: rtl/perr_driver.sv
`timescale 1ns/1ps
// PERR# driver for one side. A report makes the line driven low in the
// next cycle. Consecutive reports keep it low. After the last low cycle the
// line is driven high for one cycle and then released.
// Assumes an external pad drives the line from perr_n when perr_oe is high.
module perr_driver
    import perr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic report,
    output logic perr_n,
    output logic perr_oe
);
    drv_state_e st;

    // Advance the low / high / release sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= DRV_IDLE;
        end else if (report) begin
            st <= DRV_LOW;
        end else if (st == DRV_LOW) begin
            st <= DRV_HIGH;
        end else begin
            st <= DRV_IDLE;
        end
    end

    // Decode the pin level and drive enable from the state
    assign perr_n  = (st != DRV_LOW);
    assign perr_oe = (st != DRV_IDLE);

    // R2
    report_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report |=> (!perr_n && perr_oe));
    // R3
    low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n && !report) |=> (perr_n && perr_oe));
    // R3
    release_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_oe) |-> $past(perr_n));

endmodule

// File: rtl/bridge_perr_reporter.sv
`timescale 1ns/1ps
// Top of the bridge data parity error reporter. It checks parity on both
// buses, latches the shared transaction attributes with any valid phase,
// applies the reporting policy, and drives one PERR# sequence per side.
// Assumes only one transaction is in flight across the bridge at a time.
module bridge_perr_reporter
    import perr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pri_ad,
    input  logic [CMD_W-1:0]  pri_cbe_n,
    input  logic              pri_par,
    input  logic              pri_phase_vld,
    input  logic [DATA_W-1:0] sec_ad,
    input  logic [CMD_W-1:0]  sec_cbe_n,
    input  logic              sec_par,
    input  logic              sec_phase_vld,
    input  logic [1:0]        xact_kind,
    input  logic              xact_up,
    input  logic              far_perr_seen,
    input  logic              pri_resp_en,
    input  logic              sec_resp_en,
    output logic              pri_perr_n,
    output logic              pri_perr_oe,
    output logic              sec_perr_n,
    output logic              sec_perr_oe
);
    phase_attr_t           attr_q;
    logic                  pri_err;
    logic                  sec_err;
    logic [NUM_SIDES-1:0]  rep;
    logic [NUM_SIDES-1:0]  drv_n;
    logic [NUM_SIDES-1:0]  drv_oe;
    logic                  any_vld;

    assign any_vld = pri_phase_vld || sec_phase_vld;

    // Parity checkers, one per bus
    perr_parity_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_pri_chk (
        .clk(clk), .rst_n(rst_n), .ad(pri_ad), .cbe_n(pri_cbe_n),
        .phase_vld(pri_phase_vld), .par(pri_par), .par_err(pri_err)
    );
    perr_parity_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_sec_chk (
        .clk(clk), .rst_n(rst_n), .ad(sec_ad), .cbe_n(sec_cbe_n),
        .phase_vld(sec_phase_vld), .par(sec_par), .par_err(sec_err)
    );

    // Latch the attributes of a valid phase alongside its parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '{any_vld: 1'b0, kind: XK_READ, up: 1'b0, fwd: 1'b0};
        end else begin
            attr_q.any_vld <= any_vld;
            attr_q.kind    <= xact_kind_e'(xact_kind);
            attr_q.up      <= xact_up;
            attr_q.fwd     <= far_perr_seen && any_vld;
        end
    end

    // Decide which sides report
    perr_policy u_policy (
        .clk(clk), .rst_n(rst_n), .pri_err(pri_err), .sec_err(sec_err),
        .attr(attr_q), .pri_en(pri_resp_en), .sec_en(sec_resp_en),
        .pri_rep(rep[SIDE_PRI]), .sec_rep(rep[SIDE_SEC])
    );

    // One output driver per side
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        perr_driver u_drv (
            .clk(clk), .rst_n(rst_n), .report(rep[s]),
            .perr_n(drv_n[s]), .perr_oe(drv_oe[s])
        );
    end

    assign pri_perr_n  = drv_n[SIDE_PRI];
    assign pri_perr_oe = drv_oe[SIDE_PRI];
    assign sec_perr_n  = drv_n[SIDE_SEC];
    assign sec_perr_oe = drv_oe[SIDE_SEC];

    // R10
    no_phase_no_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_phase_vld || sec_phase_vld) |=> ##1 !(rep[SIDE_PRI] || rep[SIDE_SEC]) || $past(any_vld, 2) || $past(any_vld, 1));

endmodule

// File: tb/test_bridge_perr_reporter.sv
`timescale 1ns/1ps
// Directed bench for the bridge parity error reporter.
module test_bridge_perr_reporter;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_RD = 2'b00, K_PW = 2'b01, K_DW = 2'b10, K_RS = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] pri_ad = '0, sec_ad = '0;
    logic [3:0]  pri_cbe_n = '0, sec_cbe_n = '0;
    logic pri_par = 1'b0, sec_par = 1'b0, pri_phase_vld = 1'b0, sec_phase_vld = 1'b0;
    logic [1:0] xact_kind = '0;
    logic xact_up = 1'b0, far_perr_seen = 1'b0, pri_resp_en = 1'b1, sec_resp_en = 1'b1;
    logic pri_perr_n, pri_perr_oe, sec_perr_n, sec_perr_oe;
    logic pend_pp = 1'b0, pend_sp = 1'b0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_perr_reporter i_bridge_perr_reporter (
        .clk(clk), .rst_n(rst_n), .pri_ad(pri_ad), .pri_cbe_n(pri_cbe_n),
        .pri_par(pri_par), .pri_phase_vld(pri_phase_vld), .sec_ad(sec_ad),
        .sec_cbe_n(sec_cbe_n), .sec_par(sec_par), .sec_phase_vld(sec_phase_vld),
        .xact_kind(xact_kind), .xact_up(xact_up), .far_perr_seen(far_perr_seen),
        .pri_resp_en(pri_resp_en), .sec_resp_en(sec_resp_en),
        .pri_perr_n(pri_perr_n), .pri_perr_oe(pri_perr_oe),
        .sec_perr_n(sec_perr_n), .sec_perr_oe(sec_perr_oe)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Expect both sides: asserted low, driven high, or released
    task automatic expect_out(string req, logic p_n, logic p_oe, logic s_n, logic s_oe);
        chk(req, "pri_perr_n", pri_perr_n, p_n);
        chk(req, "pri_perr_oe", pri_perr_oe, p_oe);
        chk(req, "sec_perr_n", sec_perr_n, s_n);
        chk(req, "sec_perr_oe", sec_perr_oe, s_oe);
    endtask

    // One clock: deliver pending parity, optionally start a new phase
    task automatic cyc(bit v, bit pe, bit se, logic [1:0] k, bit up, bit fwd);
        @(negedge clk);
        pri_par = pend_pp;
        sec_par = pend_sp;
        pri_phase_vld = v;
        sec_phase_vld = v;
        xact_kind = k;
        xact_up = up;
        far_perr_seen = fwd;
        pri_ad = $urandom;
        sec_ad = $urandom;
        pri_cbe_n = 4'($urandom);
        sec_cbe_n = 4'($urandom);
        pend_pp = (^{pri_ad, pri_cbe_n}) ^ pe;
        pend_sp = (^{sec_ad, sec_cbe_n}) ^ se;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, K_RD, 1'b0, 1'b0);
    endtask

    // Single phase: check timing (R2), pulse and release (R3) on both sides
    task automatic single(string req, bit pe, bit se, logic [1:0] k, bit up, bit fwd,
                          bit exp_p, bit exp_s);
        cyc(1'b1, pe, se, k, up, fwd);
        idle();
        expect_out({req, "/R2 early"}, 1'b1, 1'b0, 1'b1, 1'b0);
        idle();
        expect_out(req, !exp_p, exp_p, !exp_s, exp_s);
        idle();
        expect_out({req, "/R3 high"}, 1'b1, exp_p, 1'b1, exp_s);
        idle();
        expect_out({req, "/R3 release"}, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_out("R11 in reset", 1'b1, 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        idle();
        // pending error discarded by reset (R11)
        cyc(1'b1, 1'b1, 1'b1, K_RD, 1'b1, 1'b0);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        idle();
        expect_out("R11 flush", 1'b1, 1'b0, 1'b1, 1'b0);
        idle();
        expect_out("R11 flush later", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_policy();
        single("R1 clean parity", 0, 0, K_RD, 1, 0, 0, 0);
        single("R5 up read", 1, 0, K_RD, 1, 0, 1, 0);
        single("R5 down posted", 1, 0, K_PW, 0, 0, 1, 0);
        single("R5 down delayed", 1, 0, K_DW, 0, 0, 1, 0);
        single("R6 down read", 0, 1, K_RD, 0, 0, 0, 1);
        single("R6 up posted", 0, 1, K_PW, 1, 0, 0, 1);
        single("R6 up delayed", 0, 1, K_DW, 1, 0, 0, 1);
        single("R7 down read pri", 1, 0, K_RD, 0, 0, 0, 0);
        single("R7 up read sec", 0, 1, K_RD, 1, 0, 0, 0);
        single("R7 down posted sec", 0, 1, K_PW, 0, 0, 0, 0);
        single("R7 up posted pri", 1, 0, K_PW, 1, 0, 0, 0);
        single("R7 down delayed sec", 0, 1, K_DW, 0, 0, 0, 0);
        single("R7 up delayed pri", 1, 0, K_DW, 1, 0, 0, 0);
        single("R10 reserved kind", 1, 1, K_RS, 0, 1, 0, 0);
    endtask

    task automatic t_enables();
        pri_resp_en = 1'b0;
        single("R8 pri disabled", 1, 0, K_RD, 1, 0, 0, 0);
        single("R8 sec unaffected", 0, 1, K_RD, 0, 0, 0, 1);
        pri_resp_en = 1'b1;
        sec_resp_en = 1'b0;
        single("R8 sec disabled", 0, 1, K_PW, 1, 0, 0, 0);
        single("R8 pri unaffected", 1, 0, K_PW, 0, 0, 1, 0);
        sec_resp_en = 1'b1;
    endtask

    task automatic t_forward();
        single("R9 fwd down", 0, 0, K_DW, 0, 1, 1, 0);
        single("R9 fwd up", 0, 0, K_DW, 1, 1, 0, 1);
        single("R9 fwd posted ignored", 0, 0, K_PW, 0, 1, 0, 0);
        single("R9 fwd read ignored", 0, 0, K_RD, 1, 1, 0, 0);
        sec_resp_en = 1'b0;
        single("R9 fwd down one enable", 0, 0, K_DW, 0, 1, 0, 0);
        sec_resp_en = 1'b1;
        pri_resp_en = 1'b0;
        single("R9 fwd up one enable", 0, 0, K_DW, 1, 1, 0, 0);
        pri_resp_en = 1'b1;
        // coincidence: local primary error and forwarded error on one phase
        single("R9 fwd plus local", 1, 0, K_DW, 0, 1, 1, 0);
        // indicator without a valid phase is not latched (R10)
        cyc(1'b0, 1'b0, 1'b0, K_DW, 1'b0, 1'b1);
        idle();
        idle();
        expect_out("R10 fwd without phase", 1'b1, 1'b0, 1'b1, 1'b0);
        idle();
        idle();
    endtask

    task automatic t_back_to_back();
        cyc(1'b1, 1'b1, 1'b0, K_RD, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, K_RD, 1'b1, 1'b0);
        idle();
        expect_out("R4 first low", 1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        expect_out("R4 second low", 1'b0, 1'b1, 1'b1, 1'b0);
        idle();
        expect_out("R4 high", 1'b1, 1'b1, 1'b1, 1'b0);
        idle();
        expect_out("R4 release", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_retrigger();
        cyc(1'b1, 1'b0, 1'b1, K_PW, 1'b1, 1'b0);
        idle();
        cyc(1'b1, 1'b0, 1'b1, K_PW, 1'b1, 1'b0);
        expect_out("R3 retrig low1", 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
        expect_out("R3 retrig high", 1'b1, 1'b0, 1'b1, 1'b1);
        idle();
        expect_out("R3 retrig low2", 1'b1, 1'b0, 1'b0, 1'b1);
        idle();
        expect_out("R3 retrig high2", 1'b1, 1'b0, 1'b1, 1'b1);
        idle();
        expect_out("R3 retrig release", 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        t_reset();
        t_policy();
        t_enables();
        t_forward();
        t_back_to_back();
        t_retrigger();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule